// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core services next. Each source has a pending flag and an enable bit. A single global enable masks all of them at once. Raw event inputs set the flags. When the global enable is on, the block raises a request whenever at least one source is both pending and enabled.

When the core acknowledges the request, the block latches the vector address of the winning source. Sources are ranked by vector position: index 0 of the source vector has the highest priority, and the reset vector sits below it at address 0. On the same acknowledge, the block clears that source's flag and drops the global enable.

Software works the block through a small register write port. The enable register is written whole. The flag register is write-one-to-clear. A set/clear port drives the global enable, and a return-from-interrupt strobe sets the global enable again. Setting the global enable inside a handler allows nesting.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, all flags, all enables and the global enable are 0, `irq_req_o` is 0 and `vec_addr_o` is 0 (the reset vector).
- R2: An `evt_i[i]` that is high at a clock edge makes `flags_o[i]` 1 from that edge on, whatever the enable bits are.
- R3: `irq_req_o` is 1 exactly when `gie_o` is 1 and at least one bit of `flags_o & en_o` is 1. It depends on state only, not on the inputs of the current cycle.
- R4: An acknowledge (`irq_ack_i` high while `irq_req_o` is high) loads `vec_addr_o` with (i+1)*VEC_STRIDE. Here i is the lowest index among the sources that are both pending and enabled, so bit 0 has the highest priority.
- R5: `vec_addr_o` changes only on an acknowledge. An `irq_ack_i` while `irq_req_o` is 0 has no effect on any state.
- R6: An acknowledge clears `gie_o` on the next edge, even if `gie_set_i` or `reti_i` is high in the same cycle.
- R7: An acknowledge clears only the flag of the winning source. All other flags keep their values.
- R8: `reti_i` or `gie_set_i` sets `gie_o`, and `gie_clr_i` clears it. When clear and set are both high in the same cycle, the clear wins.
- R9: A write with `reg_sel_i`=1 clears every flag whose `reg_wdata_i` bit is 1. Flags whose bit is 0 are unchanged.
- R10: If `evt_i[i]` is high in the cycle where flag i is being cleared (by software write or by acknowledge), flag i stays 1.
- R11: A write with `reg_sel_i`=0 replaces the enable register with `reg_wdata_i`. A pending source whose enable bit is 0 never causes a request.
- R12: After an acknowledge, setting the global enable again lets any enabled pending source raise a new request and be acknowledged, which allows nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Raw event lines, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = enable register, 1 = flag register (write one to clear) |
| reg_wdata_i | input | NUM_SRC | Register write data |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| irq_ack_i | input | 1 | Interrupt acknowledge from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | ADDR_W | Latched vector address |
| gie_o | output | 1 | Global enable state |
| flags_o | output | NUM_SRC | Pending flags |
| en_o | output | NUM_SRC | Enable register |

## Verification
The assertions check, on every cycle, these behaviours:
- a request never appears with the global enable off;
- an acknowledge always clears the global enable and the winner's flag;
- an event always leaves its flag set;
- the vector holds between acknowledges;
- the one-hot winner never names more than one source.

Only the bench's scenarios can show the rest:
- the priority order and the exact vector values;
- write-one-to-clear against a zero write;
- an event racing a clear;
- nesting after the global enable is set again.

The bench also compares every output against a behavioural model under a pseudo-random stimulus run.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  // Vector slot of a source: slot 0 is reset, source i occupies slot i+1.
  function automatic int unsigned vec_of(input int unsigned src, input int unsigned stride);
    return (src + 1) * stride;
  endfunction

  // Next global-enable value; acknowledge dominates, then clear, then set/return.
  function automatic logic gie_next(input logic cur, input logic take,
                                    input logic clr, input logic set);
    if (take)     return 1'b0;
    else if (clr) return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign win_oh[g]   = pend[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | pend[g];
  end

  assign any = seen[N];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (win_oh[i]) win_idx = IW'(i);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] flags
);
  // A new event outranks both kinds of clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~sw_clr & ~hw_clr) | evt;
  end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic clr,
  input  logic set,
  output logic gie
);
  import irq_vector_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) gie <= 1'b0;
    else        gie <= gie_next(gie, take, clr, set);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC    = 8,
  parameter int VEC_STRIDE = 2,
  parameter int ADDR_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                reg_we_i,
  input  logic                reg_sel_i,
  input  logic [NUM_SRC-1:0]  reg_wdata_i,
  input  logic                gie_set_i,
  input  logic                gie_clr_i,
  input  logic                irq_ack_i,
  input  logic                reti_i,
  output logic                irq_req_o,
  output logic [ADDR_W-1:0]   vec_addr_o,
  output logic                gie_o,
  output logic [NUM_SRC-1:0]  flags_o,
  output logic [NUM_SRC-1:0]  en_o
);
  import irq_vector_pkg::*;

  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Named internal events, visible to the bound checker.
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] win_oh_w;
  logic [IW-1:0]      win_idx_w;
  logic               any_w;
  logic               take_w;
  logic [NUM_SRC-1:0] sw_clr_w;
  logic [NUM_SRC-1:0] hw_clr_w;
  logic [ADDR_W-1:0]  win_vec_w;

  assign pend_w    = flags_o & en_o;
  assign irq_req_o = gie_o & any_w;
  assign take_w    = irq_ack_i & irq_req_o;
  assign sw_clr_w  = (reg_we_i && reg_sel_i) ? reg_wdata_i : '0;
  assign hw_clr_w  = take_w ? win_oh_w : '0;
  assign win_vec_w = ADDR_W'(vec_of(int'(win_idx_w), VEC_STRIDE));

  irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc (
    .pend    (pend_w),
    .any     (any_w),
    .win_oh  (win_oh_w),
    .win_idx (win_idx_w)
  );

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_i),
    .sw_clr (sw_clr_w),
    .hw_clr (hw_clr_w),
    .flags  (flags_o)
  );

  irq_gie_ctrl u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_w),
    .clr   (gie_clr_i),
    .set   (gie_set_i | reti_i),
    .gie   (gie_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o       <= '0;
      vec_addr_o <= '0;
    end else begin
      if (reg_we_i && !reg_sel_i) en_o <= reg_wdata_i;
      if (take_w)                 vec_addr_o <= win_vec_w;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N  = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic          irq_req_o,
  input logic          gie_o,
  input logic [N-1:0]  flags_o,
  input logic [N-1:0]  en_o,
  input logic [AW-1:0] vec_addr_o,
  input logic          take_w,
  input logic [N-1:0]  win_oh_w
);
  // R3: no request while globally masked
  p_req_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> gie_o);

  // R6: acknowledge drops the global enable
  p_ack_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> !gie_o);

  // R7: acknowledge clears the winner flag unless a fresh event hits it
  p_ack_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> ((flags_o & $past(win_oh_w & ~evt_i)) == '0));

  // R2: an event always leaves its flag set
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  // R5: vector holds without acknowledge
  p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> $stable(vec_addr_o));

  // R4: at most one winner
  p_win_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh_w));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(NUM_SRC), .AW(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .irq_req_o  (irq_req_o),
  .gie_o      (gie_o),
  .flags_o    (flags_o),
  .en_o       (en_o),
  .vec_addr_o (vec_addr_o),
  .take_w     (take_w),
  .win_oh_w   (win_oh_w)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int N = 8;
  localparam int STRIDE = 2;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [N-1:0] reg_wdata_i = '0;
  logic gie_set_i = 1'b0, gie_clr_i = 1'b0, irq_ack_i = 1'b0, reti_i = 1'b0;
  logic irq_req_o, gie_o;
  logic [AW-1:0] vec_addr_o;
  logic [N-1:0] flags_o, en_o;

  always #10 clk = ~clk;  // 50 MHz

  irq_vector_ctrl #(.NUM_SRC(N), .VEC_STRIDE(STRIDE), .ADDR_W(AW)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
    .irq_ack_i(irq_ack_i), .reti_i(reti_i), .irq_req_o(irq_req_o),
    .vec_addr_o(vec_addr_o), .gie_o(gie_o), .flags_o(flags_o), .en_o(en_o));

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural reference state
  bit [N-1:0] m_fl, m_en;
  bit m_gie;
  int m_vec;

  function automatic bit m_req();
    return m_gie && ((m_fl & m_en) != 0);
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " flags"}, flags_o, m_fl);
    chk({tag, " en"}, en_o, m_en);
    chk({tag, " gie"}, gie_o, m_gie);
    chk({tag, " vec"}, vec_addr_o, m_vec);
    chk({tag, " req"}, irq_req_o, m_req());
  endtask

  // One cycle: drive after negedge, model updates at posedge, compare at next negedge.
  task automatic step(input string tag, input bit [N-1:0] ev, input bit we, input bit sel,
                      input bit [N-1:0] wd, input bit gs, input bit gc, input bit ak,
                      input bit rt);
    bit take;
    bit [N-1:0] hw;
    evt_i = ev; reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    gie_set_i = gs; gie_clr_i = gc; irq_ack_i = ak; reti_i = rt;
    @(posedge clk);
    take = ak && m_req();
    hw = '0;
    if (take) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_fl[i] && m_en[i]) begin
          hw = '0;
          hw[i] = 1'b1;
          m_vec = (i + 1) * STRIDE;
        end
    end
    m_fl = (m_fl & ~((we && sel) ? wd : '0) & ~hw) | ev;
    if (we && !sel) m_en = wd;
    if (take || gc) m_gie = 0;
    else if (gs || rt) m_gie = 1;
    @(negedge clk);
    evt_i = '0; reg_we_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
    gie_set_i = 0; gie_clr_i = 0; irq_ack_i = 0; reti_i = 0;
    cmp_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, '0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit [15:0] lfsr;
    m_fl = '0; m_en = '0; m_gie = 0; m_vec = 0;
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", flags_o, 0);
    chk("R1 req in reset", irq_req_o, 0);
    chk("R1 vec in reset", vec_addr_o, 0);
    rst_n = 1'b1;
    // R1: first cycle out of reset
    idle("R1");
    chk("R1 gie after reset", gie_o, 0);
    chk("R1 en after reset", en_o, 0);

    // R2/R11: events latch with enables off; no request
    step("R2", 8'h24, 0, 0, '0, 0, 0, 0, 0);
    chk("R2 flags latched", flags_o, 8'h24);
    step("R11", '0, 0, 0, '0, 1, 0, 0, 0);
    chk("R11 disabled sources no req", irq_req_o, 0);
    // R11/R3: enable write raises request
    step("R11", '0, 1, 0, 8'hFF, 0, 0, 0, 0);
    chk("R11 enable reg", en_o, 8'hFF);
    chk("R3 req with gie and pending", irq_req_o, 1);

    // R4/R6/R7: acknowledge picks source 2 (lowest index), vector (2+1)*2=6
    step("R4", '0, 0, 0, '0, 1, 0, 1, 0);
    chk("R4 vector of source 2", vec_addr_o, 6);
    chk("R6 gie cleared despite set", gie_o, 0);
    chk("R7 only winner cleared", flags_o, 8'h20);
    chk("R3 no req with gie off", irq_req_o, 0);

    // R5: acknowledge without request ignored
    step("R5", '0, 0, 0, '0, 0, 0, 1, 0);
    chk("R5 vec unchanged", vec_addr_o, 6);
    chk("R5 flags unchanged", flags_o, 8'h20);

    // R8: reti sets gie; source 5 -> vector 12
    step("R8", '0, 0, 0, '0, 0, 0, 0, 1);
    chk("R8 reti sets gie", gie_o, 1);
    step("R4", '0, 0, 0, '0, 0, 0, 1, 0);
    chk("R4 vector of source 5", vec_addr_o, 12);

    // R12: nesting, handler re-enables, source 0 preempts (vector 2)
    step("R12", 8'h01, 0, 0, '0, 1, 0, 0, 0);
    chk("R12 req after re-enable", irq_req_o, 1);
    step("R12", '0, 0, 0, '0, 0, 0, 1, 0);
    chk("R12 nested vector", vec_addr_o, 2);

    // R9: write-one clears, zero leaves alone
    step("R9", 8'h81, 0, 0, '0, 0, 0, 0, 0);
    step("R9", '0, 1, 1, 8'h01, 0, 0, 0, 0);
    chk("R9 one clears bit0", flags_o, 8'h80);
    step("R9", '0, 1, 1, 8'h00, 0, 0, 0, 0);
    chk("R9 zero write no effect", flags_o, 8'h80);

    // R10: event vs software clear, event wins
    step("R10", 8'h80, 1, 1, 8'h80, 0, 0, 0, 0);
    chk("R10 event beats sw clear", flags_o, 8'h80);
    // R10: event vs acknowledge clear of the same source
    step("R10", '0, 0, 0, '0, 1, 0, 0, 0);
    step("R10", 8'h80, 0, 0, '0, 0, 0, 1, 0);
    chk("R10 event beats hw clear", flags_o, 8'h80);
    chk("R4 vector of source 7", vec_addr_o, 16);

    // R8: clear beats set/reti in same cycle
    step("R8", '0, 0, 0, '0, 1, 0, 0, 0);
    step("R8", '0, 0, 0, '0, 1, 1, 0, 1);
    chk("R8 clear wins", gie_o, 0);

    // Pseudo-random run compared against the model every cycle (R2..R12)
    lfsr = 16'hACE1;
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4 random", (lfsr[2:0] == 0) ? N'(1 << lfsr[6:4]) : '0,
           lfsr[7] & lfsr[8], lfsr[9], N'(lfsr[15:8]),
           lfsr[10] & lfsr[11], lfsr[12] & lfsr[13] & lfsr[14],
           lfsr[3], lfsr[11] & lfsr[5]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule